// File: doc/BRIEF.md
# Multiplexed Hex Seven-Segment Driver

This block displays a 24-bit value as six hexadecimal characters on a time-multiplexed seven-segment display. All six digits share one 8-line segment bus: seven segments plus a decimal point, all active low. Each digit also has its own active-low enable line. A prescaler derives a one-cycle tick from the system clock about once per millisecond. Each tick moves a scan index to the next digit. The scan is fast enough that the eye sees all six characters lit together.

For the current scan position, the block selects the matching nibble of the value and drives only that digit's enable. A 16-word by 8-bit synchronous ROM converts the nibble into a glyph. The ROM contents are fixed when the design is elaborated.

The digit enable is delayed by the same number of registers as the ROM path. The enable and the glyph therefore switch on the same clock edge, and a digit never briefly shows its neighbour's glyph. The input value is captured once per complete scan, so every digit in one pass comes from the same value.

Top module: `hex_scan_display`

## Requirements
- R1: While `rst_n` is low, and from the moment it falls (asynchronously), `seg_n_o` is 8'hFF and `dig_n_o` is 6'h3F. The display is therefore dark.
- R2: Out of reset, at most one bit of `dig_n_o` is low at any time. For scan index k, the low bit is bit (5-k).
- R3: Scan index k shows the nibble `value[23-4k : 20-4k]`. The leftmost digit (bit 5 of `dig_n_o`) therefore carries the most significant nibble.
- R4: `seg_n_o` carries the active-low glyph of the nibble shown. Glyphs are given in hex, nibble:pattern. Digits: 0:C0 1:F9 2:A4 3:B0 4:99 5:92 6:82 7:F8 8:80 9:90. Letters: A:88 b:83 C:C6 d:A1 E:86 F:8E.
- R5: The scan index advances only on a tick. A tick occurs once every `CLK_HZ/1000` clock cycles, so each digit stays lit for exactly that many cycles.
- R6: After index 5 the scan index returns to 0. Index 0 follows reset.
- R7: The input value is captured only on the tick that takes the index from 5 to 0. A change made partway through a scan shows on no digit until the next scan begins. Before the first capture, the captured value is 0.
- R8: The glyph and the digit enable for a scan position appear on the same clock edge. This edge is two clock edges after the index changes, and no cycle pairs one digit's enable with another digit's glyph.
- R9: Bit 7 of `seg_n_o`, the decimal point, is always high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| value_i | input | 24 | Value to display, six hex nibbles |
| seg_n_o | output | 8 | Active-low segment bus, bit 7 is the decimal point |
| dig_n_o | output | 6 | Active-low digit enables, bit 5 is the leftmost digit |

## Verification
The hardest situation to reach from the ports is a value change partway through a scan. From outside, that case looks the same as a design that samples the value continuously. The stimulus waits until a middle digit is lit and then changes the input. It then checks that a later digit in the same pass still shows the old nibble, and that the first digit of the next pass shows the new one. A cycle-by-cycle reference model, built from a queue of pending scan positions, also follows an asynchronous reset applied in the middle of a scan.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;

  localparam int NIB_W  = 4;
  localparam int SEG_W  = 8;
  localparam int GLYPHS = 1 << NIB_W;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [SEG_W-1:0] seg_t;

  // All segments off, decimal point off (active low)
  localparam seg_t SEG_DARK = 8'hFF;

  // Active-low glyph for one hex character; bit 7 is the decimal point
  function automatic seg_t glyph_of(input nib_t n);
    seg_t g;
    case (n)
      4'h0: g = 8'hC0;
      4'h1: g = 8'hF9;
      4'h2: g = 8'hA4;
      4'h3: g = 8'hB0;
      4'h4: g = 8'h99;
      4'h5: g = 8'h92;
      4'h6: g = 8'h82;
      4'h7: g = 8'hF8;
      4'h8: g = 8'h80;
      4'h9: g = 8'h90;
      4'hA: g = 8'h88;
      4'hB: g = 8'h83;
      4'hC: g = 8'hC6;
      4'hD: g = 8'hA1;
      4'hE: g = 8'h86;
      default: g = 8'h8E;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hexdisp_tick.sv
// Free-running prescaler: one-cycle enable every DIV clocks
module hexdisp_tick #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick_o = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/hexdisp_scan.sv
// Scan index, per-scan value capture and nibble selection stage
module hexdisp_scan
  import hexdisp_pkg::*;
#(
  parameter int unsigned DIGITS = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick_i,
  input  logic [DIGITS*NIB_W-1:0]           value_i,
  output logic [$clog2(DIGITS)-1:0]         idx_o,
  output logic [DIGITS*NIB_W-1:0]           snap_o,
  output nib_t                              nib_o,
  output logic [$clog2(DIGITS)-1:0]         lane_o
);

  localparam int IDX_W = $clog2(DIGITS);
  localparam int VAL_W = DIGITS * NIB_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIGITS - 1);

  function automatic logic [IDX_W-1:0] step_index(input logic [IDX_W-1:0] k);
    return (k == LAST_IDX) ? '0 : k + 1'b1;
  endfunction

  // Scan position k maps to nibble DIGITS-1-k (most significant first)
  function automatic nib_t pick_nibble(input logic [VAL_W-1:0] v,
                                       input logic [IDX_W-1:0] k);
    int pos;
    pos = (DIGITS - 1 - int'(k)) * NIB_W;
    return v[pos +: NIB_W];
  endfunction

  logic wrap_w;
  assign wrap_w = tick_i && (idx_o == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_o  <= '0;
      snap_o <= '0;
    end else begin
      if (tick_i) idx_o  <= step_index(idx_o);
      if (wrap_w) snap_o <= value_i;
    end
  end

  // Stage 1: nibble and its lane travel together toward the output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_o  <= '0;
      lane_o <= '0;
    end else begin
      nib_o  <= pick_nibble(snap_o, idx_o);
      lane_o <= idx_o;
    end
  end

endmodule

// File: rtl/hexdisp_out_stage.sv
// Stage 2: synchronous glyph ROM and the matching digit-enable register
module hexdisp_out_stage
  import hexdisp_pkg::*;
#(
  parameter int unsigned DIGITS = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  nib_t                      nib_i,
  input  logic [$clog2(DIGITS)-1:0] lane_i,
  output seg_t                      seg_n_o,
  output logic [DIGITS-1:0]         dig_n_o
);

  localparam int IDX_W = $clog2(DIGITS);

  function automatic logic [DIGITS-1:0] lane_mask(input logic [IDX_W-1:0] k);
    logic [DIGITS-1:0] one;
    one = {{(DIGITS-1){1'b0}}, 1'b1};
    return ~(one << (DIGITS - 1 - int'(k)));
  endfunction

  seg_t rom_w [GLYPHS];

  for (genvar g = 0; g < GLYPHS; g++) begin : g_rom
    assign rom_w[g] = glyph_of(nib_t'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_n_o <= SEG_DARK;
      dig_n_o <= '1;
    end else begin
      seg_n_o <= rom_w[nib_i];
      dig_n_o <= lane_mask(lane_i);
    end
  end

endmodule

// File: rtl/hex_scan_display.sv
module hex_scan_display
  import hexdisp_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned DIGITS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIGITS*4-1:0]     value_i,
  output logic [7:0]              seg_n_o,
  output logic [DIGITS-1:0]       dig_n_o
);

  localparam int unsigned TICK_DIV = (CLK_HZ >= 2000) ? CLK_HZ / 1000 : 2;
  localparam int IDX_W = $clog2(DIGITS);

  logic               tick_w;
  logic [IDX_W-1:0]   scan_idx_w;
  logic [IDX_W-1:0]   lane_w;
  logic [DIGITS*4-1:0] snap_w;
  nib_t               nib_w;

  hexdisp_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  hexdisp_scan #(.DIGITS(DIGITS)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_w),
    .value_i (value_i),
    .idx_o   (scan_idx_w),
    .snap_o  (snap_w),
    .nib_o   (nib_w),
    .lane_o  (lane_w)
  );

  hexdisp_out_stage #(.DIGITS(DIGITS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .nib_i   (nib_w),
    .lane_i  (lane_w),
    .seg_n_o (seg_n_o),
    .dig_n_o (dig_n_o)
  );

endmodule

// File: rtl/hexdisp_checker.sv
module hexdisp_checker #(
  parameter int unsigned DIGITS = 6,
  parameter int unsigned DIV    = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic [$clog2(DIGITS)-1:0] idx,
  input logic [DIGITS*4-1:0]       snap,
  input logic [7:0]                seg,
  input logic [DIGITS-1:0]         dig
);

  localparam int IDX_W = $clog2(DIGITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIGITS - 1);

  int unsigned gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap <= 0;
    else if (tick) gap <= 0;
    else           gap <= gap + 1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_dark_in_reset_R1: assert (seg == 8'hFF && dig == '1)
        else $error("display not dark during reset");
    end
  end

  assert_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dig));

  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap == DIV - 1);

  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(idx));

  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> idx == (($past(idx) == LAST_IDX) ? '0 : $past(idx) + 1'b1));

  assert_capture_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && idx == LAST_IDX) |=> $stable(snap));

  assert_point_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seg[7]);

endmodule

bind hex_scan_display hexdisp_checker #(.DIGITS(DIGITS), .DIV(TICK_DIV)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick_w),
  .idx   (scan_idx_w),
  .snap  (snap_w),
  .seg   (seg_n_o),
  .dig   (dig_n_o)
);

// File: tb/test_hex_scan_display.sv
module test_hex_scan_display;

  localparam int CLK_HZ = 10_000;
  localparam int DIV    = CLK_HZ / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] value = 24'h0;
  logic [7:0]  seg_n;
  logic [5:0]  dig_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  hex_scan_display #(.CLK_HZ(CLK_HZ), .DIGITS(6)) i_hex_scan_display (
    .clk     (clk),
    .rst_n   (rst_n),
    .value_i (value),
    .seg_n_o (seg_n),
    .dig_n_o (dig_n)
  );

  function automatic logic [7:0] ref_glyph(input int n);
    logic [7:0] t [16];
    t = '{8'hC0, 8'hF9, 8'hA4, 8'hB0, 8'h99, 8'h92, 8'h82, 8'hF8,
          8'h80, 8'h90, 8'h88, 8'h83, 8'hC6, 8'hA1, 8'h86, 8'h8E};
    return t[n & 15];
  endfunction

  function automatic logic [5:0] ref_mask(input int k);
    logic [5:0] m;
    m = 6'h3F;
    m[5-k] = 1'b0;
    return m;
  endfunction

  function automatic int ref_nib(input logic [23:0] v, input int k);
    return int'((v >> (4 * (5 - k))) & 24'hF);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: queue of scan positions awaiting display
  int          m_cnt, m_idx;
  logic [23:0] m_snap;
  int          q_nib[$];
  int          q_idx[$];
  bit          m_rst = 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0; m_snap = 24'h0; m_rst = 1'b1;
      q_nib.delete(); q_idx.delete();
      q_nib.push_back(0); q_idx.push_back(0);
    end else begin
      m_rst = 1'b0;
      q_nib.push_back(ref_nib(m_snap, m_idx));
      q_idx.push_back(m_idx);
      if (q_nib.size() > 2) begin
        void'(q_nib.pop_front());
        void'(q_idx.pop_front());
      end
      if (m_cnt == DIV - 1) begin
        m_cnt = 0;
        if (m_idx == 5) begin
          m_idx = 0;
          m_snap = value;
        end else m_idx++;
      end else m_cnt++;
    end
  end

  // Per-cycle comparison against the reference, plus watchdog
  always @(negedge clk) begin
    cycles++;
    if (m_rst) begin
      check("R1 seg dark", 32'(seg_n), 32'hFF);
      check("R1 digits off", 32'(dig_n), 32'h3F);
    end else begin
      check("R2 digit enable", 32'(dig_n), 32'(ref_mask(q_idx[0])));
      check("R4 glyph", 32'(seg_n), 32'(ref_glyph(q_nib[0])));
      check("R9 point off", 32'(seg_n[7]), 32'h1);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_digit(input int k);
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (dig_n === ref_mask(k)) break;
    end
  endtask

  task automatic show_value(input logic [23:0] v, input string tag);
    @(negedge clk);
    value = v;
    repeat (2 * 6 * DIV + 4) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      wait_digit(k);
      // R3 / R4 / R8: first cycle of a digit already carries its own glyph
      check(tag, 32'(seg_n), 32'(ref_glyph(ref_nib(v, k))));
    end
  endtask

  initial begin
    // R1: dark while reset held
    repeat (3) @(negedge clk);
    check("R1 reset seg", 32'(seg_n), 32'hFF);
    check("R1 reset dig", 32'(dig_n), 32'h3F);
    rst_n = 1'b1;

    // R7: before first capture the shown value is zero
    wait_digit(3);
    check("R7 initial zero", 32'(seg_n), 32'hC0);

    show_value(24'h012345, "R3 R8 order 012345");
    show_value(24'h6789AB, "R4 glyphs 6789AB");
    show_value(24'hCDEF10, "R4 glyphs CDEF10");

    // R5: dwell per digit
    wait_digit(2);
    begin
      int dwell = 0;
      while (dig_n === ref_mask(2)) begin
        dwell++;
        @(negedge clk);
      end
      check("R5 dwell cycles", 32'(dwell), 32'(DIV));
      // R6: next after 2 is 3
      check("R6 step 2->3", 32'(dig_n), 32'(ref_mask(3)));
    end
    wait_digit(5);
    wait_digit(0);
    check("R6 wrap 5->0", 32'(dig_n), 32'h1F);

    // R7: change while middle digit lit
    value = 24'hA1B2C3;
    repeat (2 * 6 * DIV + 4) @(negedge clk);
    wait_digit(2);
    value = 24'h5E6F70;
    wait_digit(4);
    check("R7 old value kept", 32'(seg_n), 32'(ref_glyph(ref_nib(24'hA1B2C3, 4))));
    wait_digit(0);
    check("R7 new value at wrap", 32'(seg_n), 32'(ref_glyph(ref_nib(24'h5E6F70, 0))));

    // R1: asynchronous reset mid-scan
    wait_digit(3);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async seg", 32'(seg_n), 32'hFF);
    check("R1 async dig", 32'(dig_n), 32'h3F);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R6: index 0 after reset, R8 two-edge latency
    @(negedge clk);
    @(negedge clk);
    check("R6 R8 restart digit", 32'(dig_n), 32'h1F);
    repeat (200) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule